// File: doc/BRIEF.md
# I2C Target Bus Engine with Strap-Selected Address

This block is the bus side of an I2C target that sits in front of a converter's command layer. It runs on a fast system clock and oversamples the SCL and SDA lines. It finds START, repeated START and STOP conditions and receives the address byte. It then acknowledges that byte or leaves it unacknowledged. After an acknowledged address it moves data bytes in either direction, MSB first. It pulls SDA low only through an open-drain enable and has no SCL output at all.

The low four address bits come from two strap inputs. Each strap input carries a 2-bit code that has already been resolved from a four-level pin. The block latches these codes once per frame, early in the address byte. The block also handles two further cases:
- It accepts the general-call address. A following reset byte produces a reset pulse.
- It abandons a stalled frame after a fixed number of modulator clock ticks. The number of ticks depends on the converter's speed mode.

The command layer sees a simple byte-level handshake. Received bytes arrive with a one-cycle valid pulse. Bytes to be sent are taken from `tx_data` on the cycle marked by `tx_next`.

Top module: `i2c_strap_target`

## Requirements
- R1: A falling SDA while SCL is high gives a one-cycle `start_o` pulse. A rising SDA while SCL is high gives a one-cycle `stop_o` pulse. SDA is released on both events.
- R2: The target address is binary `100` followed by `strap_a1` and then `strap_a0` (address bits 3:2 and 1:0). Each strap code is 00 for ground, 01 for supply, 10 for tied to SDA and 11 for tied to SCL. When the address matches, SDA is pulled low during the ninth clock.
- R3: When the address does not match, SDA stays released for the ACK and for the rest of the frame. No received byte is reported.
- R4: The strap codes are captured at the first SCL falling edge after a START. A strap change after that point has no effect until the next START.
- R5: In a write, each data byte is received MSB first and reported on `rx_data` with a one-cycle `rx_valid` pulse. Each byte is acknowledged. The number of bytes is unlimited.
- R6: In a read, `tx_data` is captured with a `tx_next` pulse at the end of each ACK clock and shifted out MSB first. A master ACK continues the transfer. A master NACK stops all SDA driving until the next START or STOP.
- R7: The general-call address 0000000 with R/W=0 is acknowledged. A following byte of 06h gives one `gc_reset` pulse. Any other byte gives no pulse. Neither case produces `rx_valid`. General call with R/W=1 is not acknowledged.
- R8: Once a frame has started, suppose no SCL edge is seen for `TMO_NORMAL` ticks of `mod_tick` (or `TMO_TURBO` ticks when `turbo_i` is 1). The block then pulses `timeout_o`, releases SDA and ignores the bus until a new START.
- R9: `sda_oe` changes only while SCL is low, except when a timeout releases it. It is 0 after reset.
- R10: A repeated START restarts the address phase at once, and the direction may change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_a1 | input | 2 | Resolved code of the upper strap pin |
| strap_a0 | input | 2 | Resolved code of the lower strap pin |
| turbo_i | input | 1 | Selects the longer timeout |
| mod_tick | input | 1 | One pulse per modulator clock |
| tx_data | input | 8 | Next byte to send in a read |
| tx_next | output | 1 | Pulse: `tx_data` was captured |
| rx_valid | output | 1 | Pulse: `rx_data` holds a received byte |
| rx_data | output | 8 | Last received byte |
| start_o | output | 1 | Pulse on START or repeated START |
| stop_o | output | 1 | Pulse on STOP |
| gc_reset | output | 1 | Pulse on general-call reset |
| timeout_o | output | 1 | Pulse when a stalled frame is abandoned |

## Verification
The assertions check four properties on every cycle:
- SDA drive never changes while SCL is high, apart from a timeout release.
- START, STOP and timeout always leave SDA released.
- The single-cycle event outputs never coincide.
- Every received byte and every general-call reset coincides with the target pulling the ACK low.

Some behaviours show up only in the bench's frames:
- the address decode over the strap codes and the latch point of those codes;
- the exact byte values in both directions;
- silence after a master NACK or an address mismatch;
- the two timeout lengths.

// File: rtl/i2c_tgt_pkg.sv
// Shared types and constants for the I2C target engine.
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WBYTE,
        ST_WACK,
        ST_RBYTE,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

    localparam logic [2:0] ADDR_PREFIX   = 3'b100;
    localparam logic [7:0] GC_RESET_BYTE = 8'h06;
    localparam int         BYTE_BITS     = 8;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Multi-stage synchroniser with edge detection for a set of bus lines.
// Assumes idle-high lines; all outputs are aligned to the same stage.
module i2c_tgt_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_i,
    output logic [N_LINES-1:0] level_o,
    output logic [N_LINES-1:0] rise_o,
    output logic [N_LINES-1:0] fall_o
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        logic              prev;

        // Shift the raw line through the stages and keep the previous level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe <= '1;
                prev <= 1'b1;
            end else begin
                pipe <= {pipe[STAGES-2:0], lines_i[g]};
                prev <= pipe[STAGES-1];
            end
        end

        assign level_o[g] = pipe[STAGES-1];
        assign rise_o[g]  = pipe[STAGES-1] & ~prev;
        assign fall_o[g]  = ~pipe[STAGES-1] & prev;
    end
endmodule

// File: rtl/i2c_tgt_timeout.sv
// Stall watchdog: counts tick pulses while a frame is active and SCL is
// still; expire_o pulses once when the mode-dependent limit is reached.
module i2c_tgt_timeout #(
    parameter int LIM_NORMAL = 14000,
    parameter int LIM_TURBO  = 28000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic kick_i,
    input  logic tick_i,
    input  logic turbo_i,
    output logic expire_o
);
    localparam int            CW    = $clog2(LIM_TURBO + 1);
    localparam logic [CW-1:0] LIM_N = CW'(LIM_NORMAL - 1);
    localparam logic [CW-1:0] LIM_T = CW'(LIM_TURBO - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = turbo_i ? LIM_T : LIM_N;

    // Count idle ticks; clear on any SCL edge or when no frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i || kick_i) begin
            cnt      <= '0;
            expire_o <= 1'b0;
        end else if (tick_i) begin
            if (cnt == last) begin
                cnt      <= '0;
                expire_o <= 1'b1;
            end else begin
                cnt      <= cnt + 1'b1;
                expire_o <= 1'b0;
            end
        end else begin
            expire_o <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
// Byte-level I2C target state machine working on synchronised line levels
// and edges. Assumes SDA changes from the master only while SCL is low,
// apart from START and STOP. START has priority over STOP and timeout.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [1:0] strap_a1,
    input  logic [1:0] strap_a0,
    input  logic [7:0] tx_data,
    input  logic       expire_i,
    output logic       active_o,
    output logic       sda_oe,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       tx_next,
    output logic       start_o,
    output logic       stop_o,
    output logic       gc_reset,
    output logic       timeout_o
);
    localparam int BCW = $clog2(BYTE_BITS + 1);

    tgt_state_e     state;
    logic [7:0]     shreg;
    logic [BCW-1:0] bitcnt;
    logic [3:0]     addr_lo;
    logic           strap_pend;
    logic           gc_mode;
    logic           mack;
    logic           start_det;
    logic           stop_det;
    logic           addr_hit;
    logic           gc_hit;

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;
    assign addr_hit  = (shreg[7:1] == {ADDR_PREFIX, addr_lo});
    assign gc_hit    = (shreg == 8'h00);
    assign active_o  = (state != ST_IDLE);

    // Main sequencer: conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bitcnt     <= '0;
            addr_lo    <= '0;
            strap_pend <= 1'b0;
            gc_mode    <= 1'b0;
            mack       <= 1'b0;
            sda_oe     <= 1'b0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            tx_next    <= 1'b0;
            start_o    <= 1'b0;
            stop_o     <= 1'b0;
            gc_reset   <= 1'b0;
            timeout_o  <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            tx_next   <= 1'b0;
            start_o   <= 1'b0;
            stop_o    <= 1'b0;
            gc_reset  <= 1'b0;
            timeout_o <= 1'b0;
            if (start_det) begin
                state      <= ST_ADDR;
                bitcnt     <= '0;
                strap_pend <= 1'b1;
                gc_mode    <= 1'b0;
                sda_oe     <= 1'b0;
                start_o    <= 1'b1;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                stop_o <= 1'b1;
            end else if (expire_i) begin
                state     <= ST_IGNORE;
                sda_oe    <= 1'b0;
                timeout_o <= 1'b1;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_fall && strap_pend) begin
                            addr_lo    <= {strap_a1, strap_a0};
                            strap_pend <= 1'b0;
                        end
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == BCW'(BYTE_BITS)) begin
                            if (addr_hit || gc_hit) begin
                                sda_oe  <= 1'b1;
                                gc_mode <= gc_hit;
                                state   <= ST_AACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_AACK, ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (state == ST_AACK && !shreg[0]) begin
                                sda_oe <= 1'b0;
                                state  <= ST_WBYTE;
                            end else if (state == ST_AACK || mack) begin
                                shreg   <= tx_data;
                                sda_oe  <= ~tx_data[7];
                                tx_next <= 1'b1;
                                state   <= ST_RBYTE;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IGNORE;
                            end
                        end
                    end
                    ST_WBYTE: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == BCW'(BYTE_BITS)) begin
                            sda_oe <= 1'b1;
                            state  <= ST_WACK;
                            if (gc_mode) begin
                                gc_reset <= (shreg == GC_RESET_BYTE);
                            end else begin
                                rx_valid <= 1'b1;
                                rx_data  <= shreg;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= gc_mode ? ST_IGNORE : ST_WBYTE;
                        end
                    end
                    ST_RBYTE: begin
                        if (scl_fall) begin
                            if (bitcnt == BCW'(BYTE_BITS - 1)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~shreg[6];
                                shreg  <= {shreg[6:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_strap_target.sv
// Top of the I2C target: line synchroniser, stall watchdog and byte engine.
// Assumes clk is at least about 10x the SCL bit rate.
module i2c_strap_target #(
    parameter int TMO_NORMAL = 14000,
    parameter int TMO_TURBO  = 28000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap_a1,
    input  logic [1:0] strap_a0,
    input  logic       turbo_i,
    input  logic       mod_tick,
    input  logic [7:0] tx_data,
    output logic       tx_next,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       start_o,
    output logic       stop_o,
    output logic       gc_reset,
    output logic       timeout_o
);
    logic [1:0] lvl;
    logic [1:0] rise;
    logic [1:0] fall;
    logic       scl_s;
    logic       active;
    logic       expire;

    assign scl_s = lvl[1];

    i2c_tgt_sync #(.N_LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .lines_i({scl_i, sda_i}),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    i2c_tgt_timeout #(.LIM_NORMAL(TMO_NORMAL), .LIM_TURBO(TMO_TURBO)) u_tmo (
        .clk(clk), .rst_n(rst_n), .active_i(active),
        .kick_i(rise[1] | fall[1]), .tick_i(mod_tick),
        .turbo_i(turbo_i), .expire_o(expire)
    );

    i2c_tgt_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(lvl[1]), .sda_lvl(lvl[0]),
        .scl_rise(rise[1]), .scl_fall(fall[1]),
        .sda_rise(rise[0]), .sda_fall(fall[0]),
        .strap_a1(strap_a1), .strap_a0(strap_a0),
        .tx_data(tx_data), .expire_i(expire), .active_o(active),
        .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_next(tx_next), .start_o(start_o), .stop_o(stop_o),
        .gc_reset(gc_reset), .timeout_o(timeout_o)
    );
endmodule

// File: rtl/i2c_strap_target_chk.sv
// Property checker for i2c_strap_target, attached by bind below.
module i2c_strap_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic rx_valid,
    input logic start_o,
    input logic stop_o,
    input logic gc_reset,
    input logic timeout_o
);
    // R9: drive is steady while SCL stays high, apart from a timeout release
    p_sda_still_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !timeout_o) |-> $stable(sda_oe));

    // R1: START and STOP leave SDA released
    p_start_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !sda_oe);
    p_stop_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !sda_oe);

    // R8: timeout releases SDA
    p_tmo_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !sda_oe);

    // R7: event pulses never coincide
    p_pulses_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, rx_valid, gc_reset, timeout_o}));

    // R5: a reported byte coincides with the ACK being driven
    p_rx_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> sda_oe);

    // R7: a general-call reset coincides with its ACK
    p_gc_acked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset |-> sda_oe);
endmodule

bind i2c_strap_target i2c_strap_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .rx_valid(rx_valid), .start_o(start_o), .stop_o(stop_o),
    .gc_reset(gc_reset), .timeout_o(timeout_o)
);

// File: tb/i2c_strap_target_bench.sv
module i2c_strap_target_bench;
    localparam int HP = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] a1 = 2'b00;
    logic [1:0] a0 = 2'b00;
    logic       turbo = 1'b0;
    logic       tick = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       sda_oe, tx_next, rx_valid, start_o, stop_o, gc_reset, timeout_o;
    logic [7:0] rx_data;
    wire        sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_strap_target u_i2c_strap_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .strap_a1(a1), .strap_a0(a0), .turbo_i(turbo),
        .mod_tick(tick), .tx_data(tx_data), .tx_next(tx_next),
        .rx_valid(rx_valid), .rx_data(rx_data), .start_o(start_o),
        .stop_o(stop_o), .gc_reset(gc_reset), .timeout_o(timeout_o)
    );

    int checks = 0, fails = 0;
    int n_start = 0, n_stop = 0, n_gc = 0, n_tmo = 0, n_rx = 0;
    logic [7:0] exp_rx[$];
    logic [7:0] tx_pool[$];
    logic [7:0] mon_e;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: counts event pulses, scoreboards received bytes, feeds tx bytes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_o) n_start++;
            if (stop_o) n_stop++;
            if (gc_reset) n_gc++;
            if (timeout_o) n_tmo++;
            if (rx_valid) begin
                n_rx++;
                if (exp_rx.size() == 0) begin
                    chk(0, "R5 unexpected rx byte", rx_data, 0);
                end else begin
                    mon_e = exp_rx.pop_front();
                    chk(rx_data == mon_e, "R5 rx byte", rx_data, mon_e);
                end
            end
            if (tx_next && tx_pool.size() > 0) tx_data = tx_pool.pop_front();
        end
    end

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_clk(input logic b, output logic s);
        sda_m = b; hw(HP);
        scl_m = 1'b1; hw(HP / 2);
        s = sda_bus; hw(HP / 2);
        scl_m = 1'b0;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hw(HP);
        scl_m = 1'b1; hw(HP);
        sda_m = 1'b0; hw(HP);
        scl_m = 1'b0; hw(HP);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hw(HP);
        scl_m = 1'b1; hw(HP);
        sda_m = 1'b1; hw(HP);
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack_n);
        logic s;
        for (int i = 7; i >= 0; i--) bit_clk(d[i], s);
        bit_clk(1'b1, ack_n);
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_clk(1'b1, s);
            d = {d[6:0], s};
        end
        bit_clk(nack, s);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        int         rx0, gc0, t0;
        hw(5);
        chk(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
        rst_n = 1'b1;
        hw(5);

        // R2/R5/R1: strap 10,01 -> address 0x49, two-byte write
        a1 = 2'b10; a0 = 2'b01;
        i2c_start();
        wr_byte({7'h49, 1'b0}, ack);
        chk(ack == 1'b0, "R2 address ack", ack, 0);
        exp_rx.push_back(8'hA5); exp_rx.push_back(8'h3C);
        wr_byte(8'hA5, ack); chk(ack == 1'b0, "R5 data ack 1", ack, 0);
        wr_byte(8'h3C, ack); chk(ack == 1'b0, "R5 data ack 2", ack, 0);
        i2c_stop(); hw(5);
        chk(n_rx == 2, "R5 byte count", n_rx, 2);
        chk(n_start == 1, "R1 start count", n_start, 1);
        chk(n_stop == 1, "R1 stop count", n_stop, 1);

        // R3: mismatch 0x48 is not acknowledged, rest of frame ignored
        i2c_start();
        wr_byte({7'h48, 1'b0}, ack);
        chk(ack == 1'b1, "R3 mismatch nack", ack, 1);
        wr_byte(8'hFF, ack);
        chk(ack == 1'b1, "R3 data after mismatch", ack, 1);
        i2c_stop(); hw(5);
        chk(n_rx == 2, "R3 no rx byte", n_rx, 2);

        // R4: strap 00,11 latched; later change to 00,00 ignored this frame
        a1 = 2'b00; a0 = 2'b11;
        i2c_start();
        a0 = 2'b00;
        wr_byte({7'h43, 1'b0}, ack);
        chk(ack == 1'b0, "R4 latched strap used", ack, 0);
        i2c_stop();
        i2c_start();
        wr_byte({7'h43, 1'b0}, ack);
        chk(ack == 1'b1, "R4 new strap at next start", ack, 1);
        i2c_stop(); hw(5);

        // R6: read at 0x40, ACK then NACK, then bus left alone
        tx_data = 8'hB2;
        tx_pool.push_back(8'h5E); tx_pool.push_back(8'h77);
        i2c_start();
        wr_byte({7'h40, 1'b1}, ack);
        chk(ack == 1'b0, "R6 read address ack", ack, 0);
        rd_byte(1'b0, d); chk(d == 8'hB2, "R6 read byte 1", d, 8'hB2);
        rd_byte(1'b1, d); chk(d == 8'h5E, "R6 read byte 2", d, 8'h5E);
        rd_byte(1'b1, d); chk(d == 8'hFF, "R6 silent after nack", d, 8'hFF);
        i2c_stop(); hw(5);

        // R10: write then repeated START into a read
        rx0 = n_rx;
        i2c_start();
        wr_byte({7'h40, 1'b0}, ack);
        exp_rx.push_back(8'h11);
        wr_byte(8'h11, ack);
        i2c_start();
        wr_byte({7'h40, 1'b1}, ack);
        chk(ack == 1'b0, "R10 repeated start address ack", ack, 0);
        rd_byte(1'b1, d); chk(d == 8'h77, "R10 read after repeated start", d, 8'h77);
        i2c_stop(); hw(5);
        chk(n_rx == rx0 + 1, "R10 write part received", n_rx, rx0 + 1);

        // R7: general call reset, other byte, read direction
        rx0 = n_rx;
        i2c_start();
        wr_byte(8'h00, ack); chk(ack == 1'b0, "R7 general call ack", ack, 0);
        wr_byte(8'h06, ack); chk(ack == 1'b0, "R7 reset byte ack", ack, 0);
        i2c_stop(); hw(5);
        chk(n_gc == 1, "R7 reset pulse", n_gc, 1);
        i2c_start();
        wr_byte(8'h00, ack);
        wr_byte(8'h07, ack);
        i2c_stop(); hw(5);
        chk(n_gc == 1, "R7 other byte no reset", n_gc, 1);
        chk(n_rx == rx0, "R7 no rx on general call", n_rx, rx0);
        i2c_start();
        wr_byte(8'h01, ack); chk(ack == 1'b1, "R7 general call read nack", ack, 1);
        i2c_stop(); hw(5);

        // R8: normal-mode timeout
        t0 = n_tmo; rx0 = n_rx;
        i2c_start();
        wr_byte({7'h40, 1'b0}, ack);
        hw(13900);
        chk(n_tmo == t0, "R8 no early timeout", n_tmo, t0);
        hw(200);
        chk(n_tmo == t0 + 1, "R8 normal timeout", n_tmo, t0 + 1);
        chk(sda_oe == 1'b0, "R8 released after timeout", sda_oe, 0);
        wr_byte(8'h22, ack);
        chk(ack == 1'b1, "R8 idle until new start", ack, 1);
        chk(n_rx == rx0, "R8 no rx after timeout", n_rx, rx0);
        i2c_stop(); hw(5);

        // R8: turbo-mode timeout is longer
        turbo = 1'b1; t0 = n_tmo;
        i2c_start();
        wr_byte({7'h40, 1'b0}, ack);
        hw(20000);
        chk(n_tmo == t0, "R8 turbo not at normal limit", n_tmo, t0);
        hw(8100);
        chk(n_tmo == t0 + 1, "R8 turbo timeout", n_tmo, t0 + 1);
        i2c_stop(); hw(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule